// File: doc/BRIEF.md
# Bus-Master Scatter/Gather DMA Engine

This block moves a disk-side word stream to and from host memory under the control of a list of memory descriptors. Software loads a base pointer to a descriptor list, gives the number of device words to move and sets the start bit. The engine then walks the list through one memory-request port. It fetches a descriptor, moves words until that region is used up, and fetches the next one. It stops when the device word count or the list runs out.

The final status shows which side ran dry first. If both end together, only the interrupt bit is left. If the list ends first, the engine falls silent with no interrupt. If the device ends first, both the active and interrupt bits are set and the engine idles until software clears the start bit. Clearing the start bit at any time aborts the transfer and throws away any word the engine holds.

Two streams connect to the device side. Words from the device come in on `dev_in_*`, and words to the device go out on `dev_out_*`. Both use valid/ready handshakes. A word moves on a rising clock edge where valid and ready are both high. The sender holds valid and keeps its data stable until ready is seen. The memory port follows the same rule for `mem_valid`/`mem_ready`. Read data comes back on `mem_rvalid` one or more cycles after the request is accepted, and it cannot be stalled. The engine keeps at most one memory request outstanding.

Top module: `bm_dma_engine`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `mem_valid`, `dev_in_ready` and `dev_out_valid` are low.
- R2: The register map is as follows.
  - Offset 0 is the command register. Bit 0 is start. Bit 3 is the direction bit: 1 means device to memory.
  - Offset 2 is the status register. Bit 0 is ACTIVE, bit 1 is ERROR and bit 2 is INTR.
  - Offset 4 is the 32-bit descriptor-list pointer. Its bits 1:0 read as zero.
  - A 0-to-1 change of start sets ACTIVE and starts a fetch at the pointer.
- R3: Each descriptor is two 32-bit words. The first is the region byte address. The second holds the byte count in bits 15:0 and the last-descriptor flag in bit 31. The next descriptor is fetched only once the current region count reaches zero, from an address 8 bytes higher.
- R4: When the device count and a last region end on the same word, status becomes INTR only (0x4) and `irq` goes high.
- R5: When the last region ends before the device count, status becomes 0x0, `irq` stays low and no further device word is accepted.
- R6: When the device count ends while list space remains, status becomes ACTIVE|INTR (0x5) and no further data moves.
- R7: Writing the command register with start = 0 clears ACTIVE at once and leaves INTR unchanged. A word taken from the device but not yet written to memory is dropped.
- R8: Writing 1 to status bit 2 clears INTR, and writing 1 to status bit 1 clears ERROR. `irq` always equals INTR.
- R9: A descriptor whose address or byte count has bits 1:0 non-zero ends the transfer with status ERROR|INTR (0x6) and moves no data.
- R10: In device-to-memory mode, incoming words are written to consecutive word addresses of the region. In memory-to-device mode, region words are read in order and presented on `dev_out_data`.
- R11: `mem_valid` and `dev_out_valid` stay high with stable address and data until accepted, unless the transfer is aborted.
- R12: A byte count of zero in bits 15:0 means 65536 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt, equal to INTR |
| dev_words | input | CNT_W | Device transfer length in words, sampled at start |
| dev_in_valid | input | 1 | Device-to-engine word valid |
| dev_in_ready | output | 1 | Engine can take a device word |
| dev_in_data | input | 32 | Device-to-engine word |
| dev_out_valid | output | 1 | Engine-to-device word valid |
| dev_out_ready | input | 1 | Device can take a word |
| dev_out_data | output | 32 | Engine-to-device word |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
A register write takes effect on the clock edge that samples it, so its effect on status, ACTIVE or `irq` can be read right after that edge. The bench drives writes and samples reads on the falling edge, half a cycle from that change.

The end of a transfer shows in status in the cycle after the final handshake plus one bookkeeping state. That timing depends on memory back-pressure, so the bench polls status on falling edges until ACTIVE drops or INTR rises, within a bounded number of cycles, and then checks the exact code. Claims that nothing more moves are checked after ten more idle cycles by comparing the source and write counters with their values at completion.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned RGN_W      = 17;

  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_PTR  = 3'd4;

  localparam int unsigned CMD_GO_BIT    = 0;
  localparam int unsigned CMD_TOMEM_BIT = 3;
  localparam int unsigned ST_ACT_BIT    = 0;
  localparam int unsigned ST_ERR_BIT    = 1;
  localparam int unsigned ST_INT_BIT    = 2;
  localparam int unsigned LAST_BIT      = 31;

  typedef enum logic [3:0] {
    W_IDLE, W_DA_REQ, W_DA_WAIT, W_DS_REQ, W_DS_WAIT, W_CHECK,
    W_IN_TAKE, W_IN_WRITE, W_MRD_REQ, W_MRD_WAIT, W_OUT_PUSH, W_HOLD
  } walk_e;
endpackage

// File: rtl/bm_regs.sv
module bm_regs
  import bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              go,
  output logic              go_tomem,
  output logic              halt,
  output logic [DATA_W-1:0] tbl_base,
  input  logic              set_intr,
  input  logic              set_err,
  input  logic              clr_active
);
  logic start_q, tomem_q, act_q, err_q, intr_q;
  logic [DATA_W-1:0] ptr_q;
  logic cmd_wr, stat_wr, ptr_wr;

  assign cmd_wr   = reg_we && (reg_addr == OFS_CMD);
  assign stat_wr  = reg_we && (reg_addr == OFS_STAT);
  assign ptr_wr   = reg_we && (reg_addr == OFS_PTR);
  assign go       = cmd_wr && reg_wdata[CMD_GO_BIT] && !start_q;
  assign halt     = cmd_wr && !reg_wdata[CMD_GO_BIT];
  assign go_tomem = reg_wdata[CMD_TOMEM_BIT];
  assign tbl_base = ptr_q;
  assign irq      = intr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0; tomem_q <= 1'b0; act_q <= 1'b0;
      err_q   <= 1'b0; intr_q  <= 1'b0; ptr_q <= '0;
    end else begin
      if (cmd_wr) begin
        start_q <= reg_wdata[CMD_GO_BIT];
        tomem_q <= reg_wdata[CMD_TOMEM_BIT];
      end
      if (ptr_wr) ptr_q <= {reg_wdata[DATA_W-1:2], 2'b00};
      if (halt)            act_q <= 1'b0;
      else if (go)         act_q <= 1'b1;
      else if (clr_active) act_q <= 1'b0;
      if (set_intr)                          intr_q <= 1'b1;
      else if (stat_wr && reg_wdata[ST_INT_BIT]) intr_q <= 1'b0;
      if (set_err)                           err_q <= 1'b1;
      else if (stat_wr && reg_wdata[ST_ERR_BIT]) err_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CMD:  reg_rdata = {{(DATA_W-4){1'b0}}, tomem_q, 2'b00, start_q};
      OFS_STAT: reg_rdata = {{(DATA_W-3){1'b0}}, intr_q, err_q, act_q};
      OFS_PTR:  reg_rdata = ptr_q;
      default:  reg_rdata = '0;
    endcase
  end

  assert_stop_clears_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !act_q);
  assert_start_sets_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> act_q);
  assert_intr_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[ST_INT_BIT] && !set_intr) |=> !intr_q);
  assert_err_raises_intr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> (err_q && intr_q));
endmodule

// File: rtl/bm_walker.sv
module bm_walker
  import bm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_tomem,
  input  logic              halt,
  input  logic [DATA_W-1:0] tbl_base,
  input  logic [CNT_W-1:0]  dev_words,
  output logic              set_intr,
  output logic              set_err,
  output logic              clr_active,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [DATA_W-1:0] dev_out_data
);
  localparam logic [RGN_W-1:0]  RGN_MAX = RGN_W'(1) << 16;
  localparam logic [RGN_W-1:0]  STEP_R  = RGN_W'(WORD_BYTES);
  localparam logic [DATA_W-1:0] STEP_A  = DATA_W'(WORD_BYTES);

  walk_e st, nxt;
  logic [DATA_W-1:0] desc_ptr, rgn_addr, buf_q;
  logic [RGN_W-1:0]  rgn_left;
  logic [CNT_W-1:0]  dev_left;
  logic              last_q, dir_q, beat_done;

  assign mem_valid     = (st == W_DA_REQ) || (st == W_DS_REQ) ||
                         (st == W_IN_WRITE) || (st == W_MRD_REQ);
  assign mem_we        = (st == W_IN_WRITE);
  assign mem_addr      = (st == W_DA_REQ) ? desc_ptr :
                         (st == W_DS_REQ) ? desc_ptr + STEP_A : rgn_addr;
  assign mem_wdata     = buf_q;
  assign dev_in_ready  = (st == W_IN_TAKE);
  assign dev_out_valid = (st == W_OUT_PUSH);
  assign dev_out_data  = buf_q;
  assign beat_done     = ((st == W_IN_WRITE) && mem_ready) ||
                         ((st == W_OUT_PUSH) && dev_out_ready);

  always_comb begin
    nxt = st; set_intr = 1'b0; set_err = 1'b0; clr_active = 1'b0;
    case (st)
      W_IDLE:     if (go) nxt = W_DA_REQ;
      W_DA_REQ:   if (mem_ready) nxt = W_DA_WAIT;
      W_DA_WAIT:  if (mem_rvalid) nxt = W_DS_REQ;
      W_DS_REQ:   if (mem_ready) nxt = W_DS_WAIT;
      W_DS_WAIT:
        if (mem_rvalid) begin
          if ((mem_rdata[1:0] != 2'b00) || (rgn_addr[1:0] != 2'b00)) begin
            set_err = 1'b1; set_intr = 1'b1; clr_active = 1'b1; nxt = W_IDLE;
          end else nxt = W_CHECK;
        end
      W_CHECK:
        if (dev_left == '0) begin
          set_intr = 1'b1;
          if ((rgn_left == '0) && last_q) begin clr_active = 1'b1; nxt = W_IDLE; end
          else nxt = W_HOLD;
        end else if (rgn_left == '0) begin
          if (last_q) begin clr_active = 1'b1; nxt = W_IDLE; end
          else nxt = W_DA_REQ;
        end else nxt = dir_q ? W_IN_TAKE : W_MRD_REQ;
      W_IN_TAKE:  if (dev_in_valid) nxt = W_IN_WRITE;
      W_IN_WRITE: if (mem_ready) nxt = W_CHECK;
      W_MRD_REQ:  if (mem_ready) nxt = W_MRD_WAIT;
      W_MRD_WAIT: if (mem_rvalid) nxt = W_OUT_PUSH;
      W_OUT_PUSH: if (dev_out_ready) nxt = W_CHECK;
      W_HOLD:     nxt = W_HOLD;
      default:    nxt = W_IDLE;
    endcase
    if (halt) nxt = W_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= W_IDLE; desc_ptr <= '0; rgn_addr <= '0; buf_q <= '0;
      rgn_left <= '0; dev_left <= '0; last_q <= 1'b0; dir_q <= 1'b0;
    end else begin
      st <= nxt;
      if (st == W_IDLE && go) begin
        desc_ptr <= tbl_base; dev_left <= dev_words; dir_q <= go_tomem;
      end
      if (st == W_DA_WAIT && mem_rvalid) rgn_addr <= mem_rdata;
      if (st == W_DS_WAIT && mem_rvalid) begin
        rgn_left <= (mem_rdata[15:0] == 16'h0) ? RGN_MAX : {1'b0, mem_rdata[15:0]};
        last_q   <= mem_rdata[LAST_BIT];
        desc_ptr <= desc_ptr + 2 * STEP_A;
      end
      if (st == W_IN_TAKE && dev_in_valid) buf_q <= dev_in_data;
      if (st == W_MRD_WAIT && mem_rvalid)  buf_q <= mem_rdata;
      if (beat_done) begin
        rgn_addr <= rgn_addr + STEP_A;
        rgn_left <= rgn_left - STEP_R;
        dev_left <= dev_left - 1'b1;
      end
    end
  end

  assert_mem_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !halt) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));
  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready && !halt) |=> (dev_out_valid && $stable(dev_out_data)));
  assert_quiet_after_device_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_CHECK && dev_left == '0) |=> (!dev_in_ready && !mem_valid && !dev_out_valid));
  assert_quiet_after_list_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_CHECK && dev_left != '0 && rgn_left == '0 && last_q) |=> (!dev_in_ready && !mem_valid));
endmodule

// File: rtl/bm_dma_engine.sv
module bm_dma_engine
  import bm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  input  logic [CNT_W-1:0]  dev_words,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [31:0]       dev_in_data,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [31:0]       dev_out_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);
  logic go, go_tomem, halt, set_intr, set_err, clr_active;
  logic [DATA_W-1:0] tbl_base;

  bm_regs u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq,
    .go, .go_tomem, .halt, .tbl_base, .set_intr, .set_err, .clr_active
  );

  bm_walker #(.CNT_W(CNT_W)) u_walker (
    .clk, .rst_n, .go, .go_tomem, .halt, .tbl_base, .dev_words,
    .set_intr, .set_err, .clr_active,
    .mem_valid, .mem_ready, .mem_we, .mem_addr, .mem_wdata, .mem_rvalid, .mem_rdata,
    .dev_in_valid, .dev_in_ready, .dev_in_data,
    .dev_out_valid, .dev_out_ready, .dev_out_data
  );
endmodule

// File: tb/bm_dma_engine_tb.sv
module bm_dma_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq;
  logic [15:0] dev_words = 16'd0;
  logic        dev_in_valid, dev_in_ready, dev_out_valid;
  logic        dev_out_ready = 1'b1;
  logic [31:0] dev_in_data, dev_out_data;
  logic        mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  bm_dma_engine u_dut (.*);

  logic [31:0] mem [0:1023];
  logic [31:0] sink [0:15];
  int unsigned src_idx = 0, wr_cnt = 0, sink_cnt = 0;
  logic src_en = 1'b0, stall_en = 1'b0, block_wr = 1'b0, mr = 1'b1;
  logic rv = 1'b0;
  logic [31:0] rd = '0;
  int vectors = 0, errors = 0;
  bit done = 0;

  assign dev_in_valid = src_en;
  assign dev_in_data  = 32'hC0DE_0000 + src_idx;
  assign mem_ready    = mr && !(block_wr && mem_we);
  assign mem_rvalid   = rv;
  assign mem_rdata    = rd;

  always @(posedge clk) begin
    mr <= stall_en ? ~mr : 1'b1;
    rv <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin mem[mem_addr[11:2]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
      else begin rv <= 1'b1; rd <= mem[mem_addr[11:2]]; end
    end
    if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;
    if (dev_out_valid && dev_out_ready && sink_cnt < 16) begin
      sink[sink_cnt] <= dev_out_data; sink_cnt <= sink_cnt + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rdreg(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic settle(output logic [31:0] s);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); rdreg(3'd2, s);
      if (!s[0] || s[2]) break;
    end
  endtask

  task automatic desc(int unsigned at, logic [31:0] a, logic [31:0] sz);
    mem[at >> 2] = a; mem[(at >> 2) + 1] = sz;
  endtask

  task automatic launch(int unsigned tbl, logic [15:0] n, logic [31:0] cmd);
    dev_words = n;
    wr(3'd4, tbl);
    wr(3'd0, cmd);
  endtask

  task automatic finish_clear();
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h6);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rdreg(3'd2, v); chk("R1 status", v, 32'h0);
    rdreg(3'd0, v); chk("R1 cmd", v, 32'h0);
    chk("R1 irq/valid/ready", {irq, mem_valid, dev_in_ready, dev_out_valid}, 4'h0);
  endtask

  task automatic t_match();
    logic [31:0] s, v; int unsigned b;
    desc(32'h000, 32'h400, 32'h8000_0010);
    b = src_idx; src_en = 1'b1;
    launch(32'h000, 16'd4, 32'h9);
    settle(s); src_en = 1'b0;
    chk("R4 status INTR only", s, 32'h4);
    chk("R8 irq follows INTR", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 4; i++) chk("R10 to-memory word", mem[(32'h400 >> 2) + i], 32'hC0DE_0000 + b + i);
    rdreg(3'd4, v); chk("R2 pointer readback", v, 32'h0);
    rdreg(3'd0, v); chk("R2 command readback", v, 32'h9);
    wr(3'd2, 32'h4);
    rdreg(3'd2, v); chk("R8 INTR cleared", v, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_short();
    logic [31:0] s; int unsigned b;
    desc(32'h020, 32'h500, 32'h8000_0008);
    mem[(32'h500 >> 2) + 2] = 32'hDEAD_BEEF;
    b = src_idx; src_en = 1'b1;
    launch(32'h020, 16'd4, 32'h9);
    settle(s);
    chk("R5 status zero", s, 32'h0);
    repeat (10) @(negedge clk);
    src_en = 1'b0;
    chk("R5 only two words taken", src_idx - b, 32'd2);
    chk("R5 word past region untouched", mem[(32'h500 >> 2) + 2], 32'hDEAD_BEEF);
    chk("R5 irq low", {31'b0, irq}, 32'h0);
    finish_clear();
  endtask

  task automatic t_long();
    logic [31:0] s, v; int unsigned b;
    desc(32'h040, 32'h600, 32'h8000_0040);
    b = src_idx; src_en = 1'b1;
    launch(32'h040, 16'd4, 32'h9);
    settle(s);
    chk("R6 status ACTIVE|INTR", s, 32'h5);
    repeat (10) @(negedge clk);
    src_en = 1'b0;
    chk("R6 no word after device end", src_idx - b, 32'd4);
    wr(3'd0, 32'h0);
    rdreg(3'd2, v); chk("R7 stop keeps INTR only", v, 32'h4);
    finish_clear();
  endtask

  task automatic t_multi();
    logic [31:0] s; int unsigned b;
    desc(32'h060, 32'h700, 32'h0000_0008);
    desc(32'h068, 32'h800, 32'h8000_0008);
    b = src_idx; src_en = 1'b1; stall_en = 1'b1;
    launch(32'h060, 16'd4, 32'h9);
    settle(s); src_en = 1'b0; stall_en = 1'b0;
    chk("R3 two-descriptor status", s, 32'h4);
    chk("R3 region1 word0", mem[32'h700 >> 2], 32'hC0DE_0000 + b);
    chk("R3 region1 word1", mem[(32'h700 >> 2) + 1], 32'hC0DE_0000 + b + 1);
    chk("R3 region2 word0", mem[32'h800 >> 2], 32'hC0DE_0000 + b + 2);
    chk("R3 region2 word1", mem[(32'h800 >> 2) + 1], 32'hC0DE_0000 + b + 3);
    finish_clear();
  endtask

  task automatic t_to_dev();
    logic [31:0] s; int unsigned b;
    desc(32'h080, 32'h900, 32'h8000_000C);
    for (int i = 0; i < 3; i++) mem[(32'h900 >> 2) + i] = 32'h5A5A_0000 + i;
    b = sink_cnt;
    launch(32'h080, 16'd3, 32'h1);
    settle(s);
    chk("R10 to-device status", s, 32'h4);
    chk("R10 to-device count", sink_cnt - b, 32'd3);
    for (int i = 0; i < 3; i++) chk("R10 to-device word", sink[b + i], 32'h5A5A_0000 + i);
    finish_clear();
  endtask

  task automatic t_abort();
    logic [31:0] v; int unsigned b, w;
    desc(32'h0A0, 32'hA00, 32'h8000_0010);
    mem[32'hA00 >> 2] = 32'h1111_2222;
    b = src_idx; w = wr_cnt; src_en = 1'b1; block_wr = 1'b1;
    launch(32'h0A0, 16'd4, 32'h9);
    for (int i = 0; i < 200 && src_idx == b; i++) @(negedge clk);
    src_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 request held under stall", {31'b0, mem_valid}, 32'h1);
    chk("R11 request address stable", mem_addr, 32'hA00);
    wr(3'd0, 32'h0);
    block_wr = 1'b0;
    rdreg(3'd2, v); chk("R7 abort status", v, 32'h0);
    repeat (10) @(negedge clk);
    chk("R7 buffered word dropped", wr_cnt - w, 32'd0);
    chk("R7 memory untouched", mem[32'hA00 >> 2], 32'h1111_2222);
  endtask

  task automatic t_err();
    logic [31:0] s, v; int unsigned b;
    desc(32'h0C0, 32'hB02, 32'h8000_0010);
    b = src_idx; src_en = 1'b1;
    launch(32'h0C0, 16'd4, 32'h9);
    settle(s); repeat (5) @(negedge clk); src_en = 1'b0;
    chk("R9 misaligned status", s, 32'h6);
    chk("R9 nothing moved", src_idx - b, 32'd0);
    wr(3'd2, 32'h2);
    rdreg(3'd2, v); chk("R8 ERROR cleared alone", v, 32'h4);
    finish_clear();
  endtask

  task automatic t_64k();
    logic [31:0] s;
    desc(32'h0E0, 32'hC00, 32'h8000_0000);
    src_en = 1'b1;
    launch(32'h0E0, 16'd4, 32'h9);
    settle(s); src_en = 1'b0;
    chk("R12 zero count is 64 KiB", s, 32'h5);
    finish_clear();
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_match();
    t_short();
    t_long();
    t_multi();
    t_to_dev();
    t_abort();
    t_err();
    t_64k();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule